// File: doc/BRIEF.md
# Per-Bit Attribute Configuration Register Bank

This block holds a small bank of 32-bit configuration dwords. Every bit follows its own access rule, chosen at build time by a parameter. Software reads and writes the bank through a simple port that carries an address and byte enables. Hardware writes into it in two ways: a load channel supplies strap-style initial values, and per-bit event inputs raise status flags.

Two reset inputs split the storage into two domains. The fundamental reset clears everything. The hot reset clears only the plain read-write and clear-on-one status bits. Sticky bits, loaded read-only bits and write-once bits keep their values across a hot reset.

The load channel uses a valid/ready handshake. A transfer happens on any clock edge where `load_valid` and `load_ready` are both high. `load_ready` drops only while the hot reset is held, so the source must hold its word during that time. At all other times the channel takes one word per cycle with no back-pressure. The software port and the event inputs are plain single-cycle strobes.

Top module: `cfg_attr_regs`

## Requirements
- R1: The 3-bit code for bit b of dword d sits at `ATTR[(d*32+b)*3 +: 3]`. The codes are: 0 reserved, 1 read-only, 2 read-write, 3 clear-on-one status, 4 write-once hardware-initialized, 5 sticky read-only, 6 sticky read-write, 7 sticky clear-on-one status.
- R2: When `sw_rd` is high at a clock edge, `rd_valid` is high in the following cycle. `rd_data` then holds the addressed dword as it stood before any update made at that same edge. When `sw_rd` is low, `rd_valid` is low in the following cycle.
- R3: A software write updates read-write bits (codes 2 and 6) with `sw_wdata`, whether each bit is 1 or 0. The write reaches only the bytes whose enable `sw_be[k]` is set, where enable k covers bits 8k+7..8k. All other bytes keep their values.
- R4: Read-only bits (codes 1 and 5) never change on a software write. They take the matching `load_data` bit when a load is accepted for their dword.
- R5: Write-once bits (code 4) take `load_data` when a load is accepted. A software write changes a byte of them only if no earlier software write has enabled that byte of that dword since the last fundamental reset. Loads never lock a byte. If a load and a software write reach such a bit in the same cycle, the load wins.
- R6: Status bits (codes 3 and 7) are set by a high `evt_set` bit. A software write of 1 to an enabled byte clears the bit, and a write of 0 leaves it unchanged. When an event and a clear reach the same bit in the same cycle, the bit ends set.
- R7: Reserved bits (code 0) always read as 0, and no write or load changes them.
- R8: While `fund_rst_n` is low, every bit goes to 0, every write-once lock clears, and `rd_valid` goes low.
- R9: On each edge where `hot_rst` is high, codes 2 and 3 go to 0 and every other bit keeps its value. Software writes, loads and events have no effect in that cycle.
- R10: `load_ready` is low while `hot_rst` is high and high otherwise. A load is accepted only when `load_valid` and `load_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, synchronous |
| hot_rst | input | 1 | Hot reset, active high, synchronous |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | ADDR_W | Dword index for software access |
| sw_be | input | 4 | Byte enables for software writes |
| sw_wdata | input | 32 | Software write data |
| rd_valid | output | 1 | Read data valid, one cycle after `sw_rd` |
| rd_data | output | 32 | Read data |
| load_valid | input | 1 | Initial-load word offered |
| load_ready | output | 1 | Initial-load word accepted when high |
| load_addr | input | ADDR_W | Dword index of the load word |
| load_data | input | 32 | Load word |
| evt_set | input | NUM_DW*32 | Per-bit status event set pulses |

## Verification
Directed sequences cover the following cases:
- Byte enables in an alternating pattern, to separate masked lanes from written lanes.
- All-ones writes over mixed dwords, to separate read-only, reserved and write-once bits from writable ones.
- An event arriving in the same cycle as a clear-on-one write, to show which side wins.
- A read issued in the same cycle as a write to the same dword, to pin the ordering of read data against the update.

Hot reset is applied with the sticky and non-sticky bits of every kind populated, to separate the two reset domains. A fundamental reset follows, to show that the write-once locks reopen. A long constrained-random run then mixes writes, loads, events, reads and occasional resets over a layout that uses every code.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;

  localparam int DW_BITS   = 32;
  localparam int DW_BYTES  = DW_BITS / 8;
  localparam int CODE_W    = 3;
  localparam int DW_ATTR_W = DW_BITS * CODE_W;

  typedef enum logic [CODE_W-1:0] {
    ATTR_RSVD = 3'd0,
    ATTR_RO   = 3'd1,
    ATTR_RW   = 3'd2,
    ATTR_W1C  = 3'd3,
    ATTR_HWI  = 3'd4,
    ATTR_ROS  = 3'd5,
    ATTR_RWS  = 3'd6,
    ATTR_W1CS = 3'd7
  } attr_e;

  // Bits that a hot reset clears; everything else survives it.
  function automatic bit cleared_on_hot(input attr_e c);
    return (c == ATTR_RW) || (c == ATTR_W1C);
  endfunction

  function automatic bit lane_has_hwi(input logic [DW_ATTR_W-1:0] m, input int ln);
    for (int k = 0; k < 8; k++)
      if (m[(ln*8+k)*CODE_W +: CODE_W] == ATTR_HWI) return 1'b1;
    return 1'b0;
  endfunction

  // Default layout exercising every code.
  function automatic logic [DW_ATTR_W-1:0] demo_dword_map(input int idx);
    logic [DW_ATTR_W-1:0] m;
    attr_e c;
    m = '0;
    for (int b = 0; b < DW_BITS; b++) begin
      case (idx)
        0: c = ATTR_RW;
        1: case (b / 8)
             0: c = ATTR_W1C;
             1: c = ATTR_W1CS;
             2: c = ATTR_RO;
             default: c = ATTR_ROS;
           endcase
        2: case (b / 8)
             0: c = ATTR_RWS;
             1: c = ATTR_HWI;
             2: c = ATTR_RSVD;
             default: c = ATTR_RW;
           endcase
        default: c = attr_e'(3'(b % 8));
      endcase
      m[b*CODE_W +: CODE_W] = c;
    end
    return m;
  endfunction

endpackage

// File: rtl/cfg_attr_dword.sv
module cfg_attr_dword
  import cfg_attr_pkg::*;
#(
  parameter logic [DW_ATTR_W-1:0] MAP = '0
) (
  input  logic               clk,
  input  logic               fund_rst_n,
  input  logic               hot_rst,
  input  logic               wr_hit,
  input  logic [DW_BYTES-1:0] be,
  input  logic [DW_BITS-1:0] wdata,
  input  logic               load_hit,
  input  logic [DW_BITS-1:0] load_data,
  input  logic [DW_BITS-1:0] evt,
  output logic [DW_BITS-1:0] q
);

  logic unused_in;
  assign unused_in = ^{load_hit, load_data, evt, wdata};

  for (genvar ln = 0; ln < DW_BYTES; ln++) begin : g_lane
    localparam bit HAS_HWI = lane_has_hwi(MAP, ln);
    logic lane_wr;
    logic lane_hwi_wr;
    logic unused_lane;

    assign lane_wr = wr_hit && be[ln] && !hot_rst;

    if (HAS_HWI) begin : g_lock
      logic locked;
      always_ff @(posedge clk) begin
        if (!fund_rst_n)  locked <= 1'b0;
        else if (lane_wr) locked <= 1'b1;
      end
      assign lane_hwi_wr = lane_wr && !locked;
    end else begin : g_nolock
      assign lane_hwi_wr = 1'b0;
    end

    assign unused_lane = lane_wr ^ lane_hwi_wr;

    for (genvar k = 0; k < 8; k++) begin : g_bit
      localparam int    I = ln*8 + k;
      localparam attr_e C = attr_e'(MAP[I*CODE_W +: CODE_W]);

      if (C == ATTR_RSVD) begin : g_rsvd
        assign q[I] = 1'b0;
      end else begin : g_store
        logic r;
        logic nxt;

        if (C == ATTR_RO || C == ATTR_ROS) begin : g_ro
          assign nxt = load_hit ? load_data[I] : r;
        end else if (C == ATTR_HWI) begin : g_hwi
          assign nxt = load_hit ? load_data[I] : (lane_hwi_wr ? wdata[I] : r);
        end else if (C == ATTR_RW || C == ATTR_RWS) begin : g_rw
          assign nxt = lane_wr ? wdata[I] : r;
        end else begin : g_w1c
          assign nxt = (r & ~(lane_wr & wdata[I])) | evt[I];
        end

        always_ff @(posedge clk) begin
          if (!fund_rst_n)  r <= 1'b0;
          else if (hot_rst) r <= cleared_on_hot(C) ? 1'b0 : r;
          else              r <= nxt;
        end

        assign q[I] = r;
      end
    end
  end

endmodule

// File: rtl/cfg_attr_rdport.sv
module cfg_attr_rdport
  import cfg_attr_pkg::*;
#(
  parameter int NUM_DW = 4,
  parameter int ADDR_W = 2
) (
  input  logic                      clk,
  input  logic                      fund_rst_n,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_DW*DW_BITS-1:0] q_flat,
  output logic                      rd_valid,
  output logic [DW_BITS-1:0]        rd_data
);

  always_ff @(posedge clk) begin
    if (!fund_rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= q_flat[addr*DW_BITS +: DW_BITS];
    end
  end

endmodule

// File: rtl/cfg_attr_regs.sv
module cfg_attr_regs
  import cfg_attr_pkg::*;
#(
  parameter int NUM_DW = 4,
  parameter int ADDR_W = 2,
  parameter logic [NUM_DW*DW_ATTR_W-1:0] ATTR =
    {demo_dword_map(3), demo_dword_map(2), demo_dword_map(1), demo_dword_map(0)}
) (
  input  logic                      clk,
  input  logic                      fund_rst_n,
  input  logic                      hot_rst,
  input  logic                      sw_wr,
  input  logic                      sw_rd,
  input  logic [ADDR_W-1:0]         sw_addr,
  input  logic [DW_BYTES-1:0]       sw_be,
  input  logic [DW_BITS-1:0]        sw_wdata,
  output logic                      rd_valid,
  output logic [DW_BITS-1:0]        rd_data,
  input  logic                      load_valid,
  output logic                      load_ready,
  input  logic [ADDR_W-1:0]         load_addr,
  input  logic [DW_BITS-1:0]        load_data,
  input  logic [NUM_DW*DW_BITS-1:0] evt_set
);

  localparam int FLAT_W = NUM_DW * DW_BITS;

  logic [FLAT_W-1:0] q_flat;
  logic              load_fire;

  assign load_ready = !hot_rst;
  assign load_fire  = load_valid && load_ready;

  for (genvar d = 0; d < NUM_DW; d++) begin : g_dw
    cfg_attr_dword #(
      .MAP(ATTR[d*DW_ATTR_W +: DW_ATTR_W])
    ) u_dw (
      .clk       (clk),
      .fund_rst_n(fund_rst_n),
      .hot_rst   (hot_rst),
      .wr_hit    (sw_wr && (sw_addr == ADDR_W'(d))),
      .be        (sw_be),
      .wdata     (sw_wdata),
      .load_hit  (load_fire && (load_addr == ADDR_W'(d))),
      .load_data (load_data),
      .evt       (evt_set[d*DW_BITS +: DW_BITS]),
      .q         (q_flat[d*DW_BITS +: DW_BITS])
    );
  end

  cfg_attr_rdport #(
    .NUM_DW(NUM_DW),
    .ADDR_W(ADDR_W)
  ) u_rd (
    .clk       (clk),
    .fund_rst_n(fund_rst_n),
    .rd        (sw_rd),
    .addr      (sw_addr),
    .q_flat    (q_flat),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/cfg_attr_chk.sv
module cfg_attr_chk
  import cfg_attr_pkg::*;
#(
  parameter int NUM_DW = 4,
  parameter int ADDR_W = 2,
  parameter logic [NUM_DW*DW_ATTR_W-1:0] ATTR = '0
) (
  input logic                      clk,
  input logic                      fund_rst_n,
  input logic                      hot_rst,
  input logic                      sw_rd,
  input logic [ADDR_W-1:0]         sw_addr,
  input logic                      rd_valid,
  input logic [DW_BITS-1:0]        rd_data,
  input logic                      load_valid,
  input logic                      load_ready,
  input logic [NUM_DW*DW_BITS-1:0] evt_set,
  input logic [NUM_DW*DW_BITS-1:0] q_flat
);

  localparam int FLAT_W = NUM_DW * DW_BITS;

  function automatic logic [FLAT_W-1:0] mask_of(input attr_e a, input attr_e b);
    logic [FLAT_W-1:0] m;
    for (int i = 0; i < FLAT_W; i++)
      m[i] = (ATTR[i*CODE_W +: CODE_W] == a) || (ATTR[i*CODE_W +: CODE_W] == b);
    return m;
  endfunction

  localparam logic [FLAT_W-1:0] RSVD_MASK = mask_of(ATTR_RSVD, ATTR_RSVD);
  localparam logic [FLAT_W-1:0] RO_MASK   = mask_of(ATTR_RO, ATTR_ROS);
  localparam logic [FLAT_W-1:0] CLR_MASK  = mask_of(ATTR_RW, ATTR_W1C);
  localparam logic [FLAT_W-1:0] W1C_MASK  = mask_of(ATTR_W1C, ATTR_W1CS);
  localparam logic [FLAT_W-1:0] KEEP_MASK = ~CLR_MASK;

  p_rd_follows_req_r2: assert property (@(posedge clk) disable iff (!fund_rst_n)
    sw_rd |=> rd_valid);

  p_no_spurious_rd_r2: assert property (@(posedge clk) disable iff (!fund_rst_n)
    !sw_rd |=> !rd_valid);

  p_rsvd_reads_zero_r7: assert property (@(posedge clk) disable iff (!fund_rst_n)
    rd_valid |-> ((rd_data & RSVD_MASK[$past(sw_addr)*DW_BITS +: DW_BITS]) == '0));

  p_ro_holds_r4: assert property (@(posedge clk) disable iff (!fund_rst_n)
    !(load_valid && load_ready) |=> ((q_flat & RO_MASK) == $past(q_flat & RO_MASK)));

  p_hot_keeps_sticky_r9: assert property (@(posedge clk) disable iff (!fund_rst_n)
    hot_rst |=> ((q_flat & KEEP_MASK) == $past(q_flat & KEEP_MASK)));

  p_hot_clears_plain_r9: assert property (@(posedge clk) disable iff (!fund_rst_n)
    hot_rst |=> ((q_flat & CLR_MASK) == '0));

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!fund_rst_n)
    !hot_rst |=> ((q_flat & $past(evt_set & W1C_MASK)) == $past(evt_set & W1C_MASK)));

  p_fund_clears_r8: assert property (@(posedge clk)
    !fund_rst_n |=> (!rd_valid && (q_flat == '0)));

endmodule

bind cfg_attr_regs cfg_attr_chk #(
  .NUM_DW(NUM_DW),
  .ADDR_W(ADDR_W),
  .ATTR  (ATTR)
) u_chk (
  .clk       (clk),
  .fund_rst_n(fund_rst_n),
  .hot_rst   (hot_rst),
  .sw_rd     (sw_rd),
  .sw_addr   (sw_addr),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .load_valid(load_valid),
  .load_ready(load_ready),
  .evt_set   (evt_set),
  .q_flat    (q_flat)
);

// File: tb/cfg_attr_regs_tb.sv
`timescale 1ns/1ps
module cfg_attr_regs_tb;

  localparam int NDW = 4;
  localparam int AW  = 2;
  localparam int NB  = NDW * 32;

  logic          clk = 1'b0;
  logic          fund_rst_n, hot_rst, sw_wr, sw_rd, load_valid;
  logic [AW-1:0] sw_addr, load_addr;
  logic [3:0]    sw_be;
  logic [31:0]   sw_wdata, load_data;
  logic [NB-1:0] evt_set;
  logic          rd_valid, load_ready;
  logic [31:0]   rd_data;

  cfg_attr_regs u_dut (
    .clk(clk), .fund_rst_n(fund_rst_n), .hot_rst(hot_rst),
    .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr), .sw_be(sw_be),
    .sw_wdata(sw_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .load_valid(load_valid), .load_ready(load_ready), .load_addr(load_addr),
    .load_data(load_data), .evt_set(evt_set)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mval [NDW];
  logic [3:0]  mlock[NDW];

  // Attribute layout of the default parameter (codes as listed in R1).
  function automatic int attr(int d, int b);
    case (d)
      0: return 2;
      1: case (b / 8) 0: return 3; 1: return 7; 2: return 1; default: return 5; endcase
      2: case (b / 8) 0: return 6; 1: return 4; 2: return 0; default: return 2; endcase
      default: return b % 8;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < NDW; d++) begin mval[d] = '0; mlock[d] = '0; end
  endtask

  task automatic model_step(bit wr, logic [AW-1:0] a, logic [3:0] be, logic [31:0] wd,
                            bit lv, logic [AW-1:0] la, logic [31:0] ld,
                            logic [NB-1:0] ev, bit hot);
    for (int d = 0; d < NDW; d++)
      for (int b = 0; b < 32; b++) begin
        int  c  = attr(d, b);
        bit  lw = wr && (a == AW'(d)) && be[b/8];
        bit  lh = lv && (la == AW'(d));
        if (hot) begin
          if (c == 2 || c == 3) mval[d][b] = 1'b0;
        end else begin
          case (c)
            0: mval[d][b] = 1'b0;
            1, 5: if (lh) mval[d][b] = ld[b];
            4: if (lh) mval[d][b] = ld[b];
               else if (lw && !mlock[d][b/8]) mval[d][b] = wd[b];
            2, 6: if (lw) mval[d][b] = wd[b];
            default: mval[d][b] = (mval[d][b] & ~(lw & wd[b])) | ev[d*32+b];
          endcase
        end
      end
    if (wr && !hot) mlock[a] = mlock[a] | be;
  endtask

  // One cycle: drive at negedge, model at posedge, check at next negedge.
  task automatic cyc(bit wr, bit rd, logic [AW-1:0] a, logic [3:0] be, logic [31:0] wd,
                     bit lv, logic [AW-1:0] la, logic [31:0] ld,
                     logic [NB-1:0] ev, bit hot, string tag);
    logic [31:0] exp;
    sw_wr = wr; sw_rd = rd; sw_addr = a; sw_be = be; sw_wdata = wd;
    load_valid = lv; load_addr = la; load_data = ld; evt_set = ev; hot_rst = hot;
    exp = mval[a];
    @(posedge clk);
    model_step(wr, a, be, wd, lv, la, ld, ev, hot);
    @(negedge clk);
    if (rd) begin
      check({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
      check(tag, rd_data, exp);
    end
    sw_wr = 0; sw_rd = 0; load_valid = 0; evt_set = '0; hot_rst = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] be, logic [31:0] wd);
    cyc(1, 0, a, be, wd, 0, 0, 0, '0, 0, "wr");
  endtask
  task automatic rdc(logic [AW-1:0] a, string tag);
    cyc(0, 1, a, 0, 0, 0, 0, 0, '0, 0, tag);
  endtask
  task automatic ld(logic [AW-1:0] a, logic [31:0] d);
    cyc(0, 0, 0, 0, 0, 1, a, d, '0, 0, "ld");
  endtask
  task automatic ev(logic [NB-1:0] e);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, e, 0, "ev");
  endtask

  task automatic fund_reset();
    fund_rst_n = 0;
    repeat (2) @(negedge clk);
    model_reset();
    check("R8 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    fund_rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    fund_rst_n = 0; hot_rst = 0; sw_wr = 0; sw_rd = 0; sw_addr = 0; sw_be = 0;
    sw_wdata = 0; load_valid = 0; load_addr = 0; load_data = 0; evt_set = '0;
    model_reset();
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    fund_reset();

    // R8: every dword reads zero after fundamental reset
    for (int d = 0; d < NDW; d++) rdc(AW'(d), "R8");
    check("R10 ready idle", {31'd0, load_ready}, 32'd1);

    // R3: alternating byte enables
    wr(0, 4'b0101, 32'hFFFF_FFFF);
    rdc(0, "R3");
    check("R3 literal", mval[0], 32'h00FF_00FF);

    // R4 / R6: load read-only bytes, raise events, then write all ones
    ld(1, 32'hA5C3_0000);
    ev({{(NB-64){1'b0}}, 32'h0000_0101, 32'h0});
    rdc(1, "R4");
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rdc(1, "R6");
    check("R6 literal", mval[1], 32'hA5C3_0000);
    // R6: event and clear collide on bit 0
    cyc(1, 0, 1, 4'h1, 32'h1, 0, 0, 0, {{(NB-64){1'b0}}, 32'h0000_0001, 32'h0}, 0, "R6 col");
    rdc(1, "R6");

    // R5 / R7: first write locks the write-once byte, reserved stays zero
    wr(2, 4'hF, 32'hFFFF_FFFF);
    rdc(2, "R7");
    check("R7 literal", mval[2], 32'hFF00_FFFF);
    wr(2, 4'hF, 32'h0);
    rdc(2, "R5");
    ld(2, 32'h0000_1200);
    rdc(2, "R5");

    // R2: read and write to same dword in one cycle return the old value
    cyc(1, 1, 0, 4'hF, 32'h1234_5678, 0, 0, 0, '0, 0, "R2");
    rdc(0, "R2");

    // R9 / R10: hot reset with a write, load and event attempted
    wr(2, 4'h1, 32'h0000_005A);
    ev({{(NB-64){1'b0}}, 32'h0000_0202, 32'h0});
    sw_wr = 1; sw_addr = 2; sw_be = 4'hF; sw_wdata = 32'h0;
    load_valid = 1; load_addr = 1; load_data = 32'h0;
    evt_set = '1; hot_rst = 1;
    #1 check("R10 ready in hot", {31'd0, load_ready}, 32'd0);
    cyc(1, 0, 2, 4'hF, 32'h0, 1, 1, 32'h0, '1, 1, "R9 hot");
    for (int d = 0; d < NDW; d++) rdc(AW'(d), "R9");

    // R8 / R5: fundamental reset reopens write-once locks
    fund_reset();
    wr(2, 4'h2, 32'h0000_3C00);
    rdc(2, "R8");

    // R1: random mix over every attribute code
    for (int n = 0; n < 4000; n++) begin
      logic [NB-1:0] e;
      e = '0;
      for (int d = 0; d < NDW; d++)
        e[d*32 +: 32] = $urandom() & $urandom() & $urandom();
      if ($urandom() % 600 == 0) fund_reset();
      cyc($urandom() % 2 == 0, $urandom() % 2 == 0, AW'($urandom()), 4'($urandom()),
          $urandom(), $urandom() % 4 == 0, AW'($urandom()), $urandom(),
          e, $urandom() % 60 == 0, "R1");
    end

    finish_run();
  end

endmodule